// File: doc/BRIEF.md
# Conditional Select With Operand Transform

This unit executes one 32-bit conditional-select instruction per transfer. It decodes the instruction word and checks the 4-bit condition field against the incoming N, Z, C, V flags. If the condition holds, it returns the first source value. If it fails, it returns the second source value after an optional increment, bitwise inversion or two's-complement negation. A source register index of 15 reads as the constant zero. The register file and the flag generation sit outside the unit. The caller presents the instruction together with both source values and the current flags, and it never gets a flag update back.

Instructions enter on a valid/ready stream and results leave on a second valid/ready stream. With the default output stage, each result appears one cycle after its input is accepted. The unit takes a new input when its output slot is empty or is being emptied in the same cycle, so back-pressure on the output stalls the input directly. Every result falls into exactly one of three outcomes: a register write, a reserved-combination report, or a report that the word belongs to another encoding.

Top module: `csel_unit`

## Requirements
- R1: A word matches only when bits [31:20] equal 0xEA5 and bits [15:14] equal 2'b10. The fields are rn = [19:16], op = [13:12], rd = [11:8], cond = [7:4] and rm = [3:0]. Any other word gives out_nomatch=1, out_wr_en=0 and out_undef=0.
- R2: A matching word with rm = 13 gives out_nomatch=1, out_wr_en=0 and out_undef=0, even when its other fields are reserved.
- R3: If out_nomatch is not raised, then rd = 13, rd = 15, rn = 13 or cond of 14 or more gives out_undef=1 and out_wr_en=0.
- R4: For a legal word whose condition holds, out_result equals the rn source value and out_wr_en=1.
- R5: For a legal word whose condition fails, out_result is derived from the rm source value by op: 0 passes it unchanged, 1 adds one (modulo 2^32), 2 inverts every bit, 3 negates it in two's complement.
- R6: A source index of 15, on either rn or rm, supplies zero in place of the input value, and the R5 transforms apply to that zero.
- R7: With in_flags = {N,Z,C,V}, cond 0..13 mean EQ Z, NE !Z, CS C, CC !C, MI N, PL !N, VS V, VC !V, HI C&!Z, LS !(C&!Z), GE N==V, LT N!=V, GT !Z&(N==V), LE !(!Z&(N==V)).
- R8: in_ready = !out_valid | out_ready. An input accepted at a clock edge produces out_valid=1 after that edge.
- R9: While out_valid=1 and out_ready=0, out_valid and every output field hold their values.
- R10: After reset, out_valid=0 and in_ready=1.
- R11: In each result, at most one of out_wr_en, out_undef and out_nomatch is set. When out_wr_en=0, out_result is zero.
- R12: out_rd carries the decoded rd field of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Unit can take the input this cycle |
| in_insn | input | 32 | Instruction word |
| in_rn_val | input | 32 | Value of register rn |
| in_rm_val | input | 32 | Value of register rm |
| in_flags | input | 4 | Flags {N,Z,C,V} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Selected value, zero when not writing |
| out_rd | output | 4 | Destination register index |
| out_wr_en | output | 1 | Write out_result to rd |
| out_undef | output | 1 | Reserved register or condition combination |
| out_nomatch | output | 1 | Word is not this instruction |

## Verification
The assertions assume that the consumer does not rely on anything changing while out_ready is low. They also assume that the source values are the register contents for the decoded indices, and the unit never checks this. The bench keeps in_valid and its payload steady from the moment it offers a word until that word is accepted. It moves inputs only between clock edges and gates out_ready with a fixed pattern, so that stall cycles and back-to-back transfers both occur. The stimulus covers all fourteen defined conditions against all sixteen flag patterns and every transform at its wrap points. It also drives each reserved index or condition and the priority of the rm = 13 case over the reserved cases.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [1:0] {
    XF_PASS = 2'd0,
    XF_INC  = 2'd1,
    XF_INV  = 2'd2,
    XF_NEG  = 2'd3
  } xform_e;

  localparam int unsigned IDX_W   = 4;
  localparam int unsigned COND_W  = 4;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned HDR_W   = 12;
  localparam logic [HDR_W-1:0] HDR_CODE = 12'hEA5;
  localparam logic [1:0]  MID_CODE = 2'b10;
  localparam logic [IDX_W-1:0] IDX_SP   = 4'd13;
  localparam logic [IDX_W-1:0] IDX_ZERO = 4'd15;
  localparam logic [COND_W-1:0] COND_FIRST_RSVD = 4'd14;

  // flag bit positions inside the {N,Z,C,V} vector
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_C = 1;
  localparam int unsigned FLG_V = 0;

  typedef struct packed {
    logic              match;
    logic              rsvd;
    logic [IDX_W-1:0]  rn;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  rm;
    logic [COND_W-1:0] cond;
    xform_e            op;
  } csel_dec_t;
endpackage

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output csel_dec_t         dec
);
  localparam int unsigned RN_LO   = INSN_W - HDR_W - IDX_W;
  localparam int unsigned MID_LO  = RN_LO - 2;
  localparam int unsigned OP_LO   = MID_LO - 2;
  localparam int unsigned RD_LO   = OP_LO - IDX_W;
  localparam int unsigned COND_LO = RD_LO - COND_W;
  localparam int unsigned RM_LO   = COND_LO - IDX_W;

  always_comb begin
    dec.rn   = insn[RN_LO +: IDX_W];
    dec.op   = xform_e'(insn[OP_LO +: 2]);
    dec.rd   = insn[RD_LO +: IDX_W];
    dec.cond = insn[COND_LO +: COND_W];
    dec.rm   = insn[RM_LO +: IDX_W];
    dec.match = (insn[INSN_W-1 -: HDR_W] == HDR_CODE) &&
                (insn[MID_LO +: 2] == MID_CODE);
    // combinations the instruction leaves undefined
    dec.rsvd = (dec.rd == IDX_SP) || (dec.rd == IDX_ZERO) ||
               (dec.rn == IDX_SP) || (dec.cond >= COND_FIRST_RSVD);
  end
endmodule

// File: rtl/csel_cond_eval.sv
module csel_cond_eval
  import csel_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              holds
);
  logic n, z, c, v, base;

  always_comb begin
    n = flags[FLG_N];
    z = flags[FLG_Z];
    c = flags[FLG_C];
    v = flags[FLG_V];
    // the upper three bits pick a test, the low bit inverts it
    unique case (cond[3:1])
      3'd0:    base = z;
      3'd1:    base = c;
      3'd2:    base = n;
      3'd3:    base = v;
      3'd4:    base = c & ~z;
      3'd5:    base = (n == v);
      3'd6:    base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    holds = base ^ cond[0];
  end
endmodule

// File: rtl/csel_operand.sv
module csel_operand
  import csel_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] val,
  input  xform_e            op,
  output logic [DATA_W-1:0] shaped
);
  logic [DATA_W-1:0] base;

  always_comb begin
    base = (idx == IDX_ZERO) ? '0 : val;
    unique case (op)
      XF_PASS: shaped = base;
      XF_INC:  shaped = base + DATA_W'(1);
      XF_INV:  shaped = ~base;
      default: shaped = (~base) + DATA_W'(1);
    endcase
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned INSN_W  = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_rn_val,
  input  logic [DATA_W-1:0] in_rm_val,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_rd,
  output logic              out_wr_en,
  output logic              out_undef,
  output logic              out_nomatch
);
  csel_dec_t         dec;
  logic              cond_ok;
  logic [DATA_W-1:0] rn_shaped, rm_shaped;
  logic              nxt_nm, nxt_ud, nxt_wr;
  logic [DATA_W-1:0] nxt_res;

  csel_decode #(.INSN_W(INSN_W)) u_dec (.insn(in_insn), .dec(dec));

  csel_cond_eval u_cond (.cond(dec.cond), .flags(in_flags), .holds(cond_ok));

  csel_operand #(.DATA_W(DATA_W)) u_rn (
    .idx(dec.rn), .val(in_rn_val), .op(XF_PASS), .shaped(rn_shaped)
  );
  csel_operand #(.DATA_W(DATA_W)) u_rm (
    .idx(dec.rm), .val(in_rm_val), .op(dec.op), .shaped(rm_shaped)
  );

  // outcome priority: foreign encoding, then reserved, then write
  always_comb begin
    nxt_nm  = ~dec.match | (dec.rm == IDX_SP);
    nxt_ud  = ~nxt_nm & dec.rsvd;
    nxt_wr  = ~nxt_nm & ~dec.rsvd;
    nxt_res = nxt_wr ? (cond_ok ? rn_shaped : rm_shaped) : '0;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic              v_q;
      logic [DATA_W-1:0] res_q;
      logic [IDX_W-1:0]  rd_q;
      logic              wr_q, ud_q, nm_q;

      assign in_ready = ~v_q | out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q   <= 1'b0;
          res_q <= '0;
          rd_q  <= '0;
          wr_q  <= 1'b0;
          ud_q  <= 1'b0;
          nm_q  <= 1'b0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) begin
            res_q <= nxt_res;
            rd_q  <= dec.rd;
            wr_q  <= nxt_wr;
            ud_q  <= nxt_ud;
            nm_q  <= nxt_nm;
          end
        end
      end

      assign out_valid   = v_q;
      assign out_result  = res_q;
      assign out_rd      = rd_q;
      assign out_wr_en   = wr_q;
      assign out_undef   = ud_q;
      assign out_nomatch = nm_q;

      assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
          $stable(out_rd) && $stable(out_wr_en) && $stable(out_undef) &&
          $stable(out_nomatch)));
    end else begin : g_pass
      assign in_ready    = out_ready;
      assign out_valid   = in_valid;
      assign out_result  = nxt_res;
      assign out_rd      = dec.rd;
      assign out_wr_en   = nxt_wr;
      assign out_undef   = nxt_ud;
      assign out_nomatch = nxt_nm;
    end
  endgenerate

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_wr_en, out_undef, out_nomatch}));

  assert_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wr_en) |-> (out_result == '0));

  assert_wr_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_en) |-> (out_rd != IDX_SP && out_rd != IDX_ZERO));
endmodule

// File: tb/csel_unit_tb_top.sv
module csel_unit_tb_top;
  typedef struct {
    logic [31:0] res;
    logic [3:0]  rd;
    logic        wr;
    logic        ud;
    logic        nm;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_rn_val = '0;
  logic [31:0] in_rm_val = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [3:0]  out_rd;
  logic        out_wr_en, out_undef, out_nomatch;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit bp_en  = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  csel_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_rn_val(in_rn_val), .in_rm_val(in_rm_val),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_rd(out_rd), .out_wr_en(out_wr_en),
    .out_undef(out_undef), .out_nomatch(out_nomatch)
  );

  function automatic logic [31:0] mk(input logic [3:0] rn, input logic [1:0] op,
                                     input logic [3:0] rd, input logic [3:0] cc,
                                     input logic [3:0] rm);
    return {12'hEA5, rn, 2'b10, op, rd, cc, rm};
  endfunction

  // R7: condition table written out case by case
  function automatic bit cond_true(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] b, input logic [3:0] f);
    exp_t e;
    logic [3:0] rn, rd, cc, rm;
    logic [1:0] op;
    logic [31:0] av, bv;
    rn = w[19:16]; op = w[13:12]; rd = w[11:8]; cc = w[7:4]; rm = w[3:0];
    e.rd = rd; e.res = '0; e.wr = 0; e.ud = 0; e.nm = 0;
    if (w[31:20] != 12'hEA5 || w[15:14] != 2'b10) begin
      e.nm = 1; e.tag = "R1";
    end else if (rm == 4'd13) begin
      e.nm = 1; e.tag = "R2";
    end else if (rd == 4'd13 || rd == 4'd15 || rn == 4'd13 || cc >= 4'd14) begin
      e.ud = 1; e.tag = "R3";
    end else begin
      e.wr = 1;
      av = (rn == 4'd15) ? 32'd0 : a;
      bv = (rm == 4'd15) ? 32'd0 : b;
      if (cond_true(cc, f)) begin
        e.res = av; e.tag = "R4/R7";
      end else begin
        case (op)
          2'd0: e.res = bv;
          2'd1: e.res = bv + 32'd1;
          2'd2: e.res = ~bv;
          default: e.res = 32'd0 - bv;
        endcase
        e.tag = "R5/R7";
      end
      if (rn == 4'd15 || rm == 4'd15) e.tag = {e.tag, "/R6"};
    end
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input logic [31:0] a,
                      input logic [31:0] b, input logic [3:0] f);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_rn_val = a; in_rm_val = b; in_flags = f;
    q.push_back(model(w, a, b, f));
    forever begin
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // back-pressure pattern
  always @(negedge clk) out_ready <= bp_en ? (cyc[1:0] != 2'b01) : 1'b1;

  // monitor / scoreboard
  initial begin
    bit stalled = 0;
    logic [31:0] h_res; logic [3:0] h_rd; logic h_wr, h_ud, h_nm;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (stalled) begin
          checks++;
          if (!out_valid || out_result != h_res || out_rd != h_rd ||
              out_wr_en != h_wr || out_undef != h_ud || out_nomatch != h_nm) begin
            fails++;
            $display("FAIL R9 hold: got v=%0b res=%h rd=%0d exp v=1 res=%h rd=%0d",
                     out_valid, out_result, out_rd, h_res, h_rd);
          end
        end
        stalled = out_valid && !out_ready;
        h_res = out_result; h_rd = out_rd; h_wr = out_wr_en;
        h_ud = out_undef; h_nm = out_nomatch;
        if (out_valid && out_ready) begin
          checks++;
          if (q.size() == 0) begin
            fails++;
            $display("FAIL R8 unexpected output res=%h expected none", out_result);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (out_result != e.res || out_rd != e.rd || out_wr_en != e.wr ||
                out_undef != e.ud || out_nomatch != e.nm) begin
              fails++;
              $display("FAIL %s R12 R11: got res=%h rd=%0d wr=%0b ud=%0b nm=%0b exp res=%h rd=%0d wr=%0b ud=%0b nm=%0b",
                       e.tag, out_result, out_rd, out_wr_en, out_undef, out_nomatch,
                       e.res, e.rd, e.wr, e.ud, e.nm);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: pending=%0d expected 0", q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: got v=%0b rdy=%0b exp v=0 rdy=1", out_valid, in_ready);
    end

    // R7: every defined condition against every flag pattern
    for (int c = 0; c < 14; c++)
      for (int f = 0; f < 16; f++)
        send(mk(4'd3, 2'(f), 4'd2, 4'(c), 4'd4), 32'h1111_0000 + 32'(c),
             32'h0000_2222 + 32'(f), 4'(f));

    // R5: transforms at wrap points (EQ with Z clear fails)
    bp_en = 1'b1;
    for (int op = 0; op < 4; op++) begin
      send(mk(4'd1, 2'(op), 4'd0, 4'd0, 4'd2), 32'hAAAA_AAAA, 32'h0000_0000, 4'b0000);
      send(mk(4'd1, 2'(op), 4'd0, 4'd0, 4'd2), 32'hAAAA_AAAA, 32'hFFFF_FFFF, 4'b0000);
      send(mk(4'd1, 2'(op), 4'd14, 4'd0, 4'd2), 32'hAAAA_AAAA, 32'h8000_0000, 4'b0000);
      send(mk(4'd14, 2'(op), 4'd12, 4'd0, 4'd14), 32'hAAAA_AAAA, 32'd5, 4'b0000);
    end

    // R6: index 15 reads zero on both sides
    send(mk(4'd15, 2'd0, 4'd1, 4'd0, 4'd2), 32'hDEAD_BEEF, 32'h1234_5678, 4'b0100);
    for (int op = 0; op < 4; op++)
      send(mk(4'd1, 2'(op), 4'd1, 4'd0, 4'd15), 32'hDEAD_BEEF, 32'h1234_5678, 4'b0000);

    // R3: reserved combinations
    send(mk(4'd1, 2'd0, 4'd13, 4'd0, 4'd2), 32'd1, 32'd2, 4'b0100);
    send(mk(4'd1, 2'd0, 4'd15, 4'd0, 4'd2), 32'd1, 32'd2, 4'b0100);
    send(mk(4'd13, 2'd0, 4'd1, 4'd0, 4'd2), 32'd1, 32'd2, 4'b0100);
    send(mk(4'd1, 2'd1, 4'd1, 4'd14, 4'd2), 32'd1, 32'd2, 4'b0000);
    send(mk(4'd1, 2'd2, 4'd1, 4'd15, 4'd2), 32'd1, 32'd2, 4'b0000);

    // R2: rm 13 beats reserved fields; R1: pattern mismatches
    send(mk(4'd1, 2'd0, 4'd1, 4'd0, 4'd13), 32'd1, 32'd2, 4'b0100);
    send(mk(4'd13, 2'd0, 4'd15, 4'd15, 4'd13), 32'd1, 32'd2, 4'b0100);
    send(mk(4'd1, 2'd0, 4'd1, 4'd0, 4'd2) ^ 32'h0000_C000, 32'd1, 32'd2, 4'b0100);
    send(mk(4'd1, 2'd0, 4'd1, 4'd0, 4'd2) ^ 32'h0010_0000 ^ 32'h0010_0000 ^ 32'h8000_0000,
         32'd1, 32'd2, 4'b0100);
    send(mk(4'd1, 2'd0, 4'd1, 4'd0, 4'd2) ^ 32'h0010_0000, 32'd1, 32'd2, 4'b0100);
    idle();

    repeat (20) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R8 drain: pending=%0d expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule